// File: doc/BRIEF.md
# Out-of-Order Micro-Op Scheduler

The scheduler is a centralized ring buffer that sits between the decode stage and the execution ports of a core. Decoded fixed-length micro-operations arrive in bundles. Each one carries a class tag, two source operand tags with ready flags, and a destination tag. The bundle is written into consecutive ring entries in program order. The decode side learns the entry index of each lane from `in_idx`, so that later completions can name the entry.

In every clock, one picker per operation class selects the oldest entry of that class that has all operands ready and has not yet issued, and presents it on that class's issue slot. Execution units report completion with the entry index and the destination tag. The tag is broadcast to all waiting sources, and the entry is marked done. Retirement walks forward from the head and commits done entries in order. A flush cuts the ring back to a chosen index.

Top module: `sched_core`

## Requirements
- R1: After reset the buffer is empty: `iss_valid` and `ret_valid` are all zero, `in_ready` is high for any bundle size up to BUNDLE, and `in_idx` lanes read 0,1,2,3.
- R2: A bundle is accepted whole or not at all. `in_ready` is high only when the number of free entries is at least `in_count`. A refused bundle writes nothing and leaves the tail unchanged.
- R3: Lane k of an accepted bundle (k < `in_count` ≤ BUNDLE) occupies entry (tail + k) mod DEPTH. The index wraps from DEPTH-1 to 0.
- R4: The classes are encoded in `in_cls` as 0 load, 1 store, 2 complex register op, 3 simple register op, 4 floating-point op, 5 branch evaluation. Issue slot bit c only carries an entry of class c that is valid, not yet issued, and has both source-ready flags set (bit 0 = source 0). The slot reports the entry's index and destination tag.
- R5: Within a class the oldest eligible entry issues first. Age is the distance from the head around the ring.
- R6: An entry issues at most once. Issue is always taken by the execution port.
- R7: A completion with tag T sets every source flag whose tag equals T at that clock edge, including sources of operations allocated in the same clock. The woken entry can issue in the following cycle.
- R8: A completion marks the entry at `cmp_idx` done when that entry is valid. Both completion channels act independently.
- R9: Up to RET_W entries retire per clock, starting at the head and stopping at the first entry that is not done. `ret_valid` lanes are contiguous from lane 0, and lane k reports entry head+k.
- R10: While `flush` is high, entries from `flush_idx` to the tail are discarded and the tail moves to `flush_idx`. A `flush_idx` equal to the head empties the buffer. In the flush cycle nothing is allocated, issued or retired.
- R11: All six classes can issue in the same clock.
- R12: The buffer holds at most DEPTH entries. When it is full, `in_ready` is low even for a one-op bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle fits and will be written |
| in_count | input | $clog2(BUNDLE+1) | Number of lanes used, from lane 0 |
| in_cls | input | BUNDLE*3 | Class code per lane |
| in_srdy | input | BUNDLE*2 | Source-ready flags per lane |
| in_stag | input | BUNDLE*2*TAG_W | Source tags, lane-major |
| in_dtag | input | BUNDLE*TAG_W | Destination tag per lane |
| in_idx | output | BUNDLE*IDX_W | Entry index each lane will occupy |
| iss_valid | output | 6 | One issue slot per class |
| iss_idx | output | 6*IDX_W | Issued entry index per class |
| iss_dtag | output | 6*TAG_W | Issued destination tag per class |
| cmp_valid | input | NCMP | Completion channel valid |
| cmp_idx | input | NCMP*IDX_W | Completed entry index |
| cmp_tag | input | NCMP*TAG_W | Broadcast destination tag |
| ret_valid | output | RET_W | Lanes committing this cycle |
| ret_idx | output | RET_W*IDX_W | Committed entry index per lane |
| ret_dtag | output | RET_W*TAG_W | Committed destination tag per lane |
| flush | input | 1 | Cut the ring back |
| flush_idx | input | IDX_W | First entry discarded; new tail |

## Verification
The bench builds the default shape: a 24-entry ring, four-lane bundles, four retire lanes, 6-bit tags and two completion channels. Because 24 is not a power of two, the modular pointer arithmetic is exercised at its real wrap point. Bundles that start at entry 22 spill into entries 0 and 1. Filling all 24 entries brings the one-free-entry refusal and the full refusal within reach. A partial flush across the wrap then leaves older entries at high indices and younger ones at low indices, which shows that the pickers order entries by ring age rather than by index.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int CLASS_N = 6;
  localparam int SRC_N   = 2;
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    OPC_LOAD  = 3'd0,
    OPC_STORE = 3'd1,
    OPC_CPLX  = 3'd2,
    OPC_SIMP  = 3'd3,
    OPC_FP    = 3'd4,
    OPC_BR    = 3'd5
  } op_class_e;

  // Position reached by stepping off places forward around a ring of n.
  function automatic int ring_step(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction

  // Distance from head forward to idx around a ring of n.
  function automatic int ring_age(input int idx, input int head, input int n);
    return (idx - head + n) % n;
  endfunction
endpackage

// File: rtl/sched_alloc.sv
module sched_alloc import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  parameter int BUNDLE = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BCW   = $clog2(BUNDLE + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [BCW-1:0]          in_count,
  input  logic [CNT_W-1:0]        count,
  input  logic [IDX_W-1:0]        tail,
  input  logic                    flush,
  output logic                    in_ready,
  output logic [BUNDLE-1:0]       lane_en,
  output logic [BUNDLE*IDX_W-1:0] lane_idx,
  output logic [BCW-1:0]          alloc_n
);
  logic fire;

  always_comb begin
    in_ready = !flush && (int'(in_count) <= (DEPTH - int'(count)));
    fire     = in_valid && in_ready;
    alloc_n  = fire ? in_count : '0;
    for (int l = 0; l < BUNDLE; l++) begin
      lane_en[l] = fire && (l < int'(in_count));
      lane_idx[l*IDX_W +: IDX_W] = IDX_W'(ring_step(int'(tail), l, DEPTH));
    end
  end

  // R3: a bundle never claims more lanes than exist
  a_r3_bundle_size: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(in_count) <= BUNDLE));
endmodule

// File: rtl/sched_pick.sv
module sched_pick import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] cand,
  input  logic [IDX_W-1:0] head,
  output logic             gnt,
  output logic [IDX_W-1:0] gnt_idx
);
  always_comb begin
    int pos;
    gnt     = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = ring_step(int'(head), k, DEPTH);
      if (!gnt && cand[pos]) begin
        gnt     = 1'b1;
        gnt_idx = IDX_W'(pos);
      end
    end
  end

  // R5: the granted slot is one of the offered candidates
  a_r5_grant_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> cand[gnt_idx]);
endmodule

// File: rtl/sched_retire.sv
module sched_retire import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  parameter int RET_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RNW   = $clog2(RET_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       head,
  input  logic [CNT_W-1:0]       count,
  input  logic [DEPTH-1:0]       done_vec,
  input  logic                   hold,
  output logic [RET_W-1:0]       ret_en,
  output logic [RET_W*IDX_W-1:0] ret_idx,
  output logic [RNW-1:0]         ret_n
);
  always_comb begin
    logic go;
    int   pos;
    go    = !hold;
    ret_n = '0;
    for (int k = 0; k < RET_W; k++) begin
      pos = ring_step(int'(head), k, DEPTH);
      ret_idx[k*IDX_W +: IDX_W] = IDX_W'(pos);
      if (go && (k < int'(count)) && done_vec[pos]) begin
        ret_en[k] = 1'b1;
        ret_n     = ret_n + 1'b1;
      end else begin
        ret_en[k] = 1'b0;
        go        = 1'b0;
      end
    end
  end

  // R9: committing lanes form an unbroken run from lane 0
  for (genvar k = 1; k < RET_W; k++) begin : g_contig
    a_r9_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en[k] |-> ret_en[k-1]);
  end
endmodule

// File: rtl/sched_core.sv
module sched_core import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  parameter int BUNDLE = 4,
  parameter int RET_W  = 4,
  parameter int TAG_W  = 6,
  parameter int NCMP   = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BCW   = $clog2(BUNDLE + 1),
  localparam int RNW   = $clog2(RET_W + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [BCW-1:0]                in_count,
  input  logic [BUNDLE*CLS_W-1:0]       in_cls,
  input  logic [BUNDLE*SRC_N-1:0]       in_srdy,
  input  logic [BUNDLE*SRC_N*TAG_W-1:0] in_stag,
  input  logic [BUNDLE*TAG_W-1:0]       in_dtag,
  output logic [BUNDLE*IDX_W-1:0]       in_idx,
  output logic [CLASS_N-1:0]            iss_valid,
  output logic [CLASS_N*IDX_W-1:0]      iss_idx,
  output logic [CLASS_N*TAG_W-1:0]      iss_dtag,
  input  logic [NCMP-1:0]               cmp_valid,
  input  logic [NCMP*IDX_W-1:0]         cmp_idx,
  input  logic [NCMP*TAG_W-1:0]         cmp_tag,
  output logic [RET_W-1:0]              ret_valid,
  output logic [RET_W*IDX_W-1:0]        ret_idx,
  output logic [RET_W*TAG_W-1:0]        ret_dtag,
  input  logic                          flush,
  input  logic [IDX_W-1:0]              flush_idx
);
  // Entry storage
  logic [DEPTH-1:0] ent_vld, ent_iss, ent_done;
  logic [CLS_W-1:0] ent_cls  [DEPTH];
  logic [SRC_N-1:0] ent_rdy  [DEPTH];
  logic [TAG_W-1:0] ent_stag [DEPTH][SRC_N];
  logic [TAG_W-1:0] ent_dtag [DEPTH];

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  // Unpacked views of the flat ports
  logic [IDX_W-1:0] cmp_idx_a [NCMP];
  logic [TAG_W-1:0] cmp_tag_a [NCMP];
  logic [IDX_W-1:0] lane_idx_a [BUNDLE];
  logic [SRC_N-1:0] lane_rdy_w [BUNDLE];

  // Named internal events
  logic [BUNDLE-1:0]       lane_en;
  logic [BUNDLE*IDX_W-1:0] lane_idx;
  logic [BCW-1:0]          alloc_n;
  logic [DEPTH-1:0]        cand [CLASS_N];
  logic [CLASS_N-1:0]      gnt;
  logic [IDX_W-1:0]        gnt_idx [CLASS_N];
  logic [DEPTH-1:0]        iss_hit, ret_hit, kill;
  logic [DEPTH-1:0]        done_vec;
  logic [RET_W-1:0]        ret_en;
  logic [RET_W*IDX_W-1:0]  ret_pos;
  logic [RNW-1:0]          ret_n;

  always_comb begin
    for (int c = 0; c < NCMP; c++) begin
      cmp_idx_a[c] = cmp_idx[c*IDX_W +: IDX_W];
      cmp_tag_a[c] = cmp_tag[c*TAG_W +: TAG_W];
    end
  end

  // Allocation
  sched_alloc #(.DEPTH(DEPTH), .BUNDLE(BUNDLE)) u_alloc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
    .count(count_q), .tail(tail_q), .flush(flush), .in_ready(in_ready),
    .lane_en(lane_en), .lane_idx(lane_idx), .alloc_n(alloc_n)
  );
  assign in_idx = lane_idx;

  // Incoming sources also see a broadcast made in the same clock
  always_comb begin
    for (int l = 0; l < BUNDLE; l++) begin
      lane_idx_a[l] = lane_idx[l*IDX_W +: IDX_W];
      for (int s = 0; s < SRC_N; s++) begin
        lane_rdy_w[l][s] = in_srdy[l*SRC_N + s];
        for (int c = 0; c < NCMP; c++)
          if (cmp_valid[c] && (in_stag[(l*SRC_N + s)*TAG_W +: TAG_W] == cmp_tag_a[c]))
            lane_rdy_w[l][s] = 1'b1;
      end
    end
  end

  // Issue: one picker per class
  for (genvar c = 0; c < CLASS_N; c++) begin : g_class
    always_comb begin
      for (int e = 0; e < DEPTH; e++)
        cand[c][e] = !flush && ent_vld[e] && !ent_iss[e] && (&ent_rdy[e])
                     && (int'(ent_cls[e]) == c);
    end
    sched_pick #(.DEPTH(DEPTH)) u_pick (
      .clk(clk), .rst_n(rst_n), .cand(cand[c]), .head(head_q),
      .gnt(gnt[c]), .gnt_idx(gnt_idx[c])
    );
    assign iss_valid[c] = gnt[c];
    assign iss_idx[c*IDX_W +: IDX_W]  = gnt_idx[c];
    assign iss_dtag[c*TAG_W +: TAG_W] = ent_dtag[gnt_idx[c]];

    // R4: the slot of class c carries an eligible entry of class c
    a_r4_issue_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[c] |-> (ent_vld[gnt_idx[c]] && (&ent_rdy[gnt_idx[c]])
                  && (int'(ent_cls[gnt_idx[c]]) == c)));
  end

  // Retirement
  always_comb begin
    for (int e = 0; e < DEPTH; e++) done_vec[e] = ent_vld[e] && ent_done[e];
  end

  sched_retire #(.DEPTH(DEPTH), .RET_W(RET_W)) u_retire (
    .clk(clk), .rst_n(rst_n), .head(head_q), .count(count_q),
    .done_vec(done_vec), .hold(flush), .ret_en(ret_en),
    .ret_idx(ret_pos), .ret_n(ret_n)
  );
  assign ret_valid = ret_en;
  assign ret_idx   = ret_pos;
  always_comb begin
    for (int k = 0; k < RET_W; k++)
      ret_dtag[k*TAG_W +: TAG_W] = ent_dtag[ret_pos[k*IDX_W +: IDX_W]];
  end

  // Per-entry events
  always_comb begin
    int fa;
    int ea;
    iss_hit = '0;
    ret_hit = '0;
    kill    = '0;
    for (int c = 0; c < CLASS_N; c++)
      if (gnt[c]) iss_hit[gnt_idx[c]] = 1'b1;
    for (int k = 0; k < RET_W; k++)
      if (ret_en[k]) ret_hit[ret_pos[k*IDX_W +: IDX_W]] = 1'b1;
    fa = ring_age(int'(flush_idx), int'(head_q), DEPTH);
    for (int e = 0; e < DEPTH; e++) begin
      ea = ring_age(e, int'(head_q), DEPTH);
      kill[e] = flush && (ea >= fa) && (ea < int'(count_q));
    end
  end

  // State update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_iss  <= '0;
      ent_done <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      count_q  <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        ent_cls[e]  <= '0;
        ent_rdy[e]  <= '0;
        ent_dtag[e] <= '0;
        for (int s = 0; s < SRC_N; s++) ent_stag[e][s] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        for (int s = 0; s < SRC_N; s++)
          for (int c = 0; c < NCMP; c++)
            if (cmp_valid[c] && (ent_stag[e][s] == cmp_tag_a[c])) ent_rdy[e][s] <= 1'b1;
        for (int c = 0; c < NCMP; c++)
          if (cmp_valid[c] && (int'(cmp_idx_a[c]) == e) && ent_vld[e]) ent_done[e] <= 1'b1;
        if (iss_hit[e]) ent_iss[e] <= 1'b1;
        if (ret_hit[e] || kill[e]) ent_vld[e] <= 1'b0;
      end
      for (int l = 0; l < BUNDLE; l++) begin
        if (lane_en[l]) begin
          ent_vld[lane_idx_a[l]]  <= 1'b1;
          ent_iss[lane_idx_a[l]]  <= 1'b0;
          ent_done[lane_idx_a[l]] <= 1'b0;
          ent_cls[lane_idx_a[l]]  <= in_cls[l*CLS_W +: CLS_W];
          ent_rdy[lane_idx_a[l]]  <= lane_rdy_w[l];
          ent_dtag[lane_idx_a[l]] <= in_dtag[l*TAG_W +: TAG_W];
          for (int s = 0; s < SRC_N; s++)
            ent_stag[lane_idx_a[l]][s] <= in_stag[(l*SRC_N + s)*TAG_W +: TAG_W];
        end
      end
      head_q <= IDX_W'(ring_step(int'(head_q), int'(ret_n), DEPTH));
      if (flush) begin
        tail_q  <= flush_idx;
        count_q <= CNT_W'(ring_age(int'(flush_idx), int'(head_q), DEPTH));
      end else begin
        tail_q  <= IDX_W'(ring_step(int'(tail_q), int'(alloc_n), DEPTH));
        count_q <= CNT_W'(int'(count_q) + int'(alloc_n) - int'(ret_n));
      end
    end
  end

  // R12: occupancy never exceeds the ring size
  a_r12_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);

  // R2: a refused bundle leaves the tail where it was
  a_r2_no_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !flush) |=> (tail_q == $past(tail_q)));

  // R10: the tail lands on the flush index
  a_r10_tail_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail_q == $past(flush_idx)));

  // R10: a flush cycle allocates, issues and retires nothing
  a_r10_quiet_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ((iss_valid == '0) && (ret_valid == '0) && !in_ready));

  // R6: a picker never selects an entry that already left
  for (genvar e = 0; e < DEPTH; e++) begin : g_once
    a_r6_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
      iss_hit[e] |-> !ent_iss[e]);
  end
endmodule

// File: tb/tb_sched_core.sv
`timescale 1ns/1ps
module tb_sched_core;
  import sched_pkg::*;
  localparam int DEPTH = 24, BUNDLE = 4, RET_W = 4, TAG_W = 6, NCMP = 2;
  localparam int IDX_W = $clog2(DEPTH), BCW = $clog2(BUNDLE + 1);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [BCW-1:0] in_count = '0;
  logic [BUNDLE*CLS_W-1:0] in_cls = '0;
  logic [BUNDLE*SRC_N-1:0] in_srdy = '0;
  logic [BUNDLE*SRC_N*TAG_W-1:0] in_stag = '0;
  logic [BUNDLE*TAG_W-1:0] in_dtag = '0;
  logic [BUNDLE*IDX_W-1:0] in_idx;
  logic [CLASS_N-1:0] iss_valid;
  logic [CLASS_N*IDX_W-1:0] iss_idx;
  logic [CLASS_N*TAG_W-1:0] iss_dtag;
  logic [NCMP-1:0] cmp_valid = '0;
  logic [NCMP*IDX_W-1:0] cmp_idx = '0;
  logic [NCMP*TAG_W-1:0] cmp_tag = '0;
  logic [RET_W-1:0] ret_valid;
  logic [RET_W*IDX_W-1:0] ret_idx;
  logic [RET_W*TAG_W-1:0] ret_dtag;
  logic flush = 0;
  logic [IDX_W-1:0] flush_idx = '0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sched_core #(.DEPTH(DEPTH), .BUNDLE(BUNDLE), .RET_W(RET_W), .TAG_W(TAG_W), .NCMP(NCMP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_count(in_count), .in_cls(in_cls), .in_srdy(in_srdy), .in_stag(in_stag),
    .in_dtag(in_dtag), .in_idx(in_idx), .iss_valid(iss_valid), .iss_idx(iss_idx),
    .iss_dtag(iss_dtag), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_tag(cmp_tag),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_dtag(ret_dtag),
    .flush(flush), .flush_idx(flush_idx)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int slot_idx(input int c);  return int'(iss_idx[c*IDX_W +: IDX_W]);  endfunction
  function automatic int slot_tag(input int c);  return int'(iss_dtag[c*TAG_W +: TAG_W]); endfunction
  function automatic int lane_at(input int l);   return int'(in_idx[l*IDX_W +: IDX_W]);   endfunction
  function automatic int ret_at(input int k);    return int'(ret_idx[k*IDX_W +: IDX_W]);  endfunction
  function automatic int rtag_at(input int k);   return int'(ret_dtag[k*TAG_W +: TAG_W]); endfunction

  // Advance to the next falling edge with all pulses cleared
  task automatic next_cycle();
    @(negedge clk);
    in_valid = 0; in_count = '0; cmp_valid = '0; flush = 0;
  endtask

  task automatic set_lane(input int l, input int cls, input int srdy,
                          input int t0, input int t1, input int dt);
    in_cls[l*CLS_W +: CLS_W] = CLS_W'(cls);
    in_srdy[l*SRC_N +: SRC_N] = SRC_N'(srdy);
    in_stag[(l*SRC_N)*TAG_W +: TAG_W]     = TAG_W'(t0);
    in_stag[(l*SRC_N + 1)*TAG_W +: TAG_W] = TAG_W'(t1);
    in_dtag[l*TAG_W +: TAG_W] = TAG_W'(dt);
  endtask

  task automatic complete(input int ch, input int idx, input int tag);
    cmp_valid[ch] = 1'b1;
    cmp_idx[ch*IDX_W +: IDX_W] = IDX_W'(idx);
    cmp_tag[ch*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  task automatic t_reset();
    next_cycle();
    in_count = 3'(BUNDLE);
    #1;
    check("R1", "in_ready", int'(in_ready), 1);
    check("R1", "iss_valid", int'(iss_valid), 0);
    check("R1", "ret_valid", int'(ret_valid), 0);
    check("R1", "lane3 index", lane_at(3), 3);
  endtask

  task automatic t_basic();
    next_cycle();
    set_lane(0, OPC_LOAD, 3, 0, 0, 10);
    set_lane(1, OPC_STORE, 3, 0, 0, 11);
    set_lane(2, OPC_LOAD, 3, 0, 0, 12);
    set_lane(3, OPC_BR, 3, 0, 0, 13);
    in_valid = 1; in_count = 3'd4;
    #1;
    check("R3", "lane2 index", lane_at(2), 2);
    next_cycle(); #1;
    check("R4", "slots load/store/branch", int'(iss_valid), 'h23);
    check("R4", "load slot index", slot_idx(0), 0);
    check("R4", "store slot tag", slot_tag(1), 11);
    check("R4", "branch slot index", slot_idx(5), 3);
    next_cycle(); #1;
    check("R6", "second load only", int'(iss_valid), 'h01);
    check("R5", "younger load index", slot_idx(0), 2);
    next_cycle(); #1;
    check("R6", "no reissue", int'(iss_valid), 0);
    next_cycle();
    complete(0, 1, 11); complete(1, 2, 12);
    #1;
    next_cycle(); #1;
    check("R9", "head not done blocks", int'(ret_valid), 0);
    next_cycle();
    complete(0, 0, 10);
    #1;
    next_cycle(); #1;
    check("R9", "three retire", int'(ret_valid), 'b0111);
    check("R9", "lane2 index", ret_at(2), 2);
    check("R8", "lane1 tag", rtag_at(1), 11);
    next_cycle();
    complete(1, 3, 13);
    #1;
    check("R9", "before last done", int'(ret_valid), 0);
    next_cycle(); #1;
    check("R8", "last retire mask", int'(ret_valid), 'b0001);
    check("R9", "last retire index", ret_at(0), 3);
  endtask

  task automatic t_wake();
    next_cycle();
    set_lane(0, OPC_LOAD, 3, 0, 0, 20);
    set_lane(1, OPC_SIMP, 1, 0, 20, 30);
    set_lane(2, OPC_SIMP, 1, 0, 21, 31);
    set_lane(3, OPC_SIMP, 1, 0, 20, 32);
    in_valid = 1; in_count = 3'd4;
    #1;
    check("R3", "base index", lane_at(0), 4);
    next_cycle(); #1;
    check("R4", "producer issues", int'(iss_valid), 'h01);
    next_cycle();
    complete(0, 4, 20);
    #1;
    check("R7", "not woken yet", int'(iss_valid), 0);
    next_cycle(); #1;
    check("R7", "woken simple", int'(iss_valid), 'h08);
    check("R5", "oldest simple", slot_idx(3), 5);
    check("R9", "producer retires", ret_at(0) + 100 * int'(ret_valid), 104);
    next_cycle(); #1;
    check("R5", "next simple", slot_idx(3), 7);
    check("R4", "next simple tag", slot_tag(3), 32);
    next_cycle(); #1;
    check("R7", "unmatched tag waits", int'(iss_valid), 0);
    next_cycle();
    complete(0, 5, 30);
    #1;
    next_cycle(); #1;
    check("R9", "stop at not done", int'(ret_valid), 'b0001);
    check("R9", "retired index", ret_at(0), 5);
    next_cycle();
    flush = 1; flush_idx = 5'd6;
    set_lane(0, OPC_LOAD, 3, 0, 0, 9);
    in_valid = 1; in_count = 3'd1;
    #1;
    check("R10", "no alloc in flush", int'(in_ready), 0);
    next_cycle();
    in_count = 3'd4;
    #1;
    check("R10", "tail moved", lane_at(0), 6);
    check("R10", "empty after flush", int'(in_ready), 1);
    check("R10", "nothing issues", int'(iss_valid), 0);
  endtask

  task automatic t_fill();
    for (int b = 0; b < 5; b++) begin
      next_cycle();
      for (int l = 0; l < 4; l++) set_lane(l, OPC_LOAD, 0, 50, 50, b*4 + l);
      in_valid = 1; in_count = 3'd4;
      #1;
      check("R2", "room for bundle", int'(in_ready), 1);
      if (b == 0) check("R3", "first lane", lane_at(0), 6);
      if (b == 4) begin
        check("R3", "wrap lane1", lane_at(1), 23);
        check("R3", "wrap lane2", lane_at(2), 0);
      end
    end
    next_cycle();
    for (int l = 0; l < 3; l++) set_lane(l, OPC_LOAD, 0, 50, 50, 20 + l);
    in_valid = 1; in_count = 3'd3;
    #1;
    check("R3", "three-lane base", lane_at(0), 2);
    next_cycle();
    in_valid = 1; in_count = 3'd2;
    #1;
    check("R2", "two do not fit in one", int'(in_ready), 0);
    next_cycle();
    set_lane(0, OPC_LOAD, 0, 50, 50, 23);
    in_valid = 1; in_count = 3'd1;
    #1;
    check("R2", "refused left tail", lane_at(0), 5);
    check("R2", "one fits", int'(in_ready), 1);
    next_cycle();
    in_valid = 1; in_count = 3'd1;
    #1;
    check("R12", "full refuses one", int'(in_ready), 0);
    next_cycle();
    flush = 1; flush_idx = 5'd2;
    #1;
    next_cycle(); #1;
    check("R10", "partial flush tail", lane_at(0), 2);
    next_cycle();
    complete(0, 23, 50);
    #1;
    check("R7", "still waiting", int'(iss_valid), 0);
    next_cycle(); #1;
    check("R5", "oldest across wrap", slot_idx(0), 6);
    check("R5", "oldest tag", slot_tag(0), 0);
    next_cycle(); #1;
    check("R5", "second across wrap", slot_idx(0), 7);
    next_cycle();
    flush = 1; flush_idx = 5'd6;
    #1;
    check("R10", "flush silences issue", int'(iss_valid), 0);
    next_cycle();
    in_count = 3'd4;
    #1;
    check("R10", "full flush empties", int'(iss_valid), 0);
    check("R10", "tail at head", lane_at(0), 6);
    check("R10", "room again", int'(in_ready), 1);
  endtask

  task automatic t_all6();
    next_cycle();
    set_lane(0, OPC_LOAD, 2, 45, 0, 60);
    set_lane(1, OPC_STORE, 2, 45, 0, 61);
    set_lane(2, OPC_CPLX, 2, 45, 0, 62);
    set_lane(3, OPC_SIMP, 2, 45, 0, 63);
    in_valid = 1; in_count = 3'd4;
    #1;
    next_cycle();
    set_lane(0, OPC_FP, 2, 45, 0, 1);
    set_lane(1, OPC_BR, 2, 45, 0, 2);
    set_lane(2, OPC_SIMP, 3, 0, 0, 45);
    in_valid = 1; in_count = 3'd3;
    #1;
    check("R4", "waiting sources hold", int'(iss_valid), 0);
    next_cycle(); #1;
    check("R4", "producer simple", slot_idx(3) + 100 * int'(iss_valid), 812);
    next_cycle();
    complete(0, 12, 45);
    set_lane(0, OPC_LOAD, 2, 45, 0, 3);
    in_valid = 1; in_count = 3'd1;
    #1;
    check("R3", "single lane index", lane_at(0), 13);
    next_cycle(); #1;
    check("R11", "all six slots", int'(iss_valid), 'h3F);
    check("R11", "store index", slot_idx(1), 7);
    check("R11", "complex index", slot_idx(2), 8);
    check("R11", "fp index", slot_idx(4), 10);
    check("R11", "branch tag", slot_tag(5), 2);
    check("R5", "older load first", slot_idx(0), 6);
    next_cycle(); #1;
    check("R7", "same-clock wake", int'(iss_valid) + 100 * slot_idx(0), 1301);
    next_cycle(); complete(0, 11, 2);  complete(1, 10, 1);  #1;
    next_cycle(); complete(0, 9, 63);  complete(1, 8, 62);  #1;
    next_cycle(); complete(0, 7, 61);  complete(1, 6, 60);  #1;
    check("R9", "head pending", int'(ret_valid), 0);
    next_cycle(); #1;
    check("R9", "four per clock", int'(ret_valid), 'b1111);
    check("R9", "lane3 index", ret_at(3), 9);
    check("R8", "lane0 tag", rtag_at(0), 60);
    next_cycle(); #1;
    check("R9", "rest up to pending", int'(ret_valid), 'b0111);
    check("R9", "lane2 index", ret_at(2), 12);
    next_cycle(); #1;
    check("R9", "pending blocks", int'(ret_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_wake();
    t_fill();
    t_all6();
    next_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule